// File: doc/BRIEF.md
# Conversion Pacer Clock Generator

This block issues conversion-start strobes to an analog-input converter from a 100 MHz system clock. It has two sources. One is an internal pacer that divides the system clock by a programmable 32-bit divisor. The other is an external clock pin, where every rising edge asks for one conversion, so the spacing between samples may be irregular. A control input selects the source.

Whichever source is active, the strobes are held to a minimum spacing of 400 system clocks, which is a ceiling of 250 kS/s. On the internal path this is done by raising any small divisor to the floor. On the external path an edge that comes too soon is discarded and recorded in a sticky overrun flag, which a clear input resets.

Top module: `conv_pacer`

## Requirements
- R1: While reset is asserted (rstN low), and on release, convStart and overrun are both 0.
- R2: With enable=1 and srcExt=0, convStart pulses once every N clock cycles, where N is the effective divisor. The first pulse appears N cycles after the first clock edge that samples enable high.
- R3: Any divisor value below 400, including 0, behaves as 400. Divisor values of 400 or more are used as given.
- R4: Every accepted conversion drives convStart high for exactly one clock cycle.
- R5: With enable=1 and srcExt=1, a rising edge on extClk passes through a two-flop synchronizer and an edge register. If the edge is accepted, convStart goes high after the third clock edge that follows the change on the pin.
- R6: Two convStart pulses are never fewer than 400 cycles apart, whichever source is active. An external edge whose strobe would land exactly 400 cycles after the previous one is accepted.
- R7: An external edge that arrives while the 400-cycle spacing has not yet elapsed produces no strobe. It sets overrun, and overrun stays set until it is cleared.
- R8: A one-cycle pulse on ovrClear returns overrun to 0 on the next clock edge.
- R9: While enable=0 there are no strobes, and extClk edges do not set overrun. The divider restarts whenever the block is disabled or the divisor or the source changes. After a divisor change the next strobe comes N+1 cycles after the change.
- R10: When srcExt=0, activity on extClk does not affect the strobes. When srcExt=1, the internal divider produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables conversion pacing |
| srcExt | input | 1 | Source select: 0 selects the internal divider, 1 selects the external pin |
| divisor | input | 32 | Internal pacer period in system clocks, with a floor of 400 |
| extClk | input | 1 | Asynchronous external conversion clock |
| ovrClear | input | 1 | Clears the overrun flag |
| convStart | output | 1 | One-cycle conversion-start strobe |
| overrun | output | 1 | Sticky flag for a dropped external edge |

## Verification
Some properties are checked on every cycle: the one-cycle pulse width, the 400-cycle minimum spacing between strobes, the silence of the output while the block is disabled, and the overrun flag's stickiness, clearing and source. Other behaviour only the bench scenarios can show. These are the exact internal period for each divisor, the clamping of small divisors, the three-edge external latency, the restart timing after a divisor change, and the accept-or-drop decision at exactly 399 and 400 cycles of spacing.

// File: rtl/conv_pacer_pkg.sv
package conv_pacer_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearDiv;  // restart the internal divider
    logic fire;      // issue a conversion strobe on the next edge
  } pacer_ctl_t;
endpackage

// File: rtl/pacer_dp.sv
module pacer_dp
  import conv_pacer_pkg::*;
#(
  parameter int DIV_W   = 32,
  parameter int MIN_GAP = 400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  pacer_ctl_t       ctl,
  output logic             divTick,
  output logic             gapReady,
  output logic             convStart
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_GAP);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] divCnt;
  logic [GAP_W-1:0] gapCnt;

  // Clamp the period so the internal pacer respects the rate ceiling
  assign effDiv  = (divisor < DIV_FLOOR) ? DIV_FLOOR : divisor;
  assign divTick = !ctl.clearDiv && (divCnt == effDiv - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)                        divCnt <= '0;
    else if (ctl.clearDiv || divTick) divCnt <= '0;
    else                              divCnt <= divCnt + 1'b1;
  end

  // Cycles since last strobe, saturating at the minimum spacing
  always_ff @(posedge clk) begin
    if (!rstN)                gapCnt <= GAP_MAX;
    else if (ctl.fire)        gapCnt <= GAP_W'(1);
    else if (gapCnt != GAP_MAX) gapCnt <= gapCnt + 1'b1;
  end
  assign gapReady = (gapCnt == GAP_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) convStart <= 1'b0;
    else       convStart <= ctl.fire;
  end
endmodule

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import conv_pacer_pkg::*;
#(
  parameter int DIV_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             srcExt,
  input  logic [DIV_W-1:0] divisor,
  input  logic             extClk,
  input  logic             ovrClear,
  input  logic             divTick,
  input  logic             gapReady,
  output pacer_ctl_t       ctl,
  output logic             overrun
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic [DIV_W-1:0]       prevDiv;
  logic                   prevSrc;
  logic                   extRise, intReq, extReq, extDrop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
      prevDiv <= '0;
      prevSrc <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extClk};
      extPrev <= syncQ[SYNC_STAGES-1];
      prevDiv <= divisor;
      prevSrc <= srcExt;
    end
  end

  assign extRise = syncQ[SYNC_STAGES-1] && !extPrev;

  always_comb begin
    ctl.clearDiv = !enable || srcExt || (divisor != prevDiv) || (srcExt != prevSrc);
    intReq       = enable && !srcExt && divTick;
    extReq       = enable && srcExt && extRise;
    ctl.fire     = gapReady && (intReq || extReq);
    extDrop      = extReq && !gapReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         overrun <= 1'b0;
    else if (extDrop)  overrun <= 1'b1;
    else if (ovrClear) overrun <= 1'b0;
  end
endmodule

// File: rtl/conv_pacer.sv
module conv_pacer
  import conv_pacer_pkg::*;
#(
  parameter int DIV_W       = 32,
  parameter int MIN_GAP     = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             srcExt,
  input  logic [DIV_W-1:0] divisor,
  input  logic             extClk,
  input  logic             ovrClear,
  output logic             convStart,
  output logic             overrun
);
  pacer_ctl_t ctl;
  logic       divTick;
  logic       gapReady;

  pacer_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) ctrlInst (
    .clk(clk), .rstN(rstN), .enable(enable), .srcExt(srcExt),
    .divisor(divisor), .extClk(extClk), .ovrClear(ovrClear),
    .divTick(divTick), .gapReady(gapReady), .ctl(ctl), .overrun(overrun)
  );

  pacer_dp #(.DIV_W(DIV_W), .MIN_GAP(MIN_GAP)) dpInst (
    .clk(clk), .rstN(rstN), .divisor(divisor), .ctl(ctl),
    .divTick(divTick), .gapReady(gapReady), .convStart(convStart)
  );
endmodule

// File: rtl/conv_pacer_chk.sv
module conv_pacer_chk #(
  parameter int MIN_GAP = 400
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic srcExt,
  input logic ovrClear,
  input logic convStart,
  input logic overrun
);
  logic [31:0] sinceCnt;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceCnt <= '0;
      seen     <= 1'b0;
    end else if (convStart) begin
      sinceCnt <= '0;
      seen     <= 1'b1;
    end else if (sinceCnt < 32'(MIN_GAP)) begin
      sinceCnt <= sinceCnt + 1'b1;
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R6
  min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && seen) |-> (sinceCnt >= 32'(MIN_GAP - 1)));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovrClear) |=> overrun);

  // R7
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(enable && srcExt));

  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClear && !(enable && srcExt)) |=> !overrun);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !convStart);
endmodule

bind conv_pacer conv_pacer_chk #(.MIN_GAP(MIN_GAP)) chkInst (
  .clk(clk), .rstN(rstN), .enable(enable), .srcExt(srcExt),
  .ovrClear(ovrClear), .convStart(convStart), .overrun(overrun)
);

// File: tb/conv_pacer_test.sv
module conv_pacer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [31:0] VEC_DIV [NVEC] = '{32'd1000, 32'd400, 32'd399, 32'd0,
                                             32'd5, 32'd777, 32'd1234, 32'd401};
  localparam int VEC_EXP [NVEC] = '{1000, 400, 400, 400, 400, 777, 1234, 401};

  logic clk = 1'b0;
  logic rstN, enable, srcExt, extClk, ovrClear;
  logic [31:0] divisor;
  logic convStart, overrun;
  int vecs = 0;
  int errs = 0;

  conv_pacer uut (
    .clk(clk), .rstN(rstN), .enable(enable), .srcExt(srcExt),
    .divisor(divisor), .extClk(extClk), .ovrClear(ovrClear),
    .convStart(convStart), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitStrobe(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!convStart && n < limit);
  endtask

  task automatic countStrobes(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (convStart) cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++;
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n, cnt, firstPos;
    rstN = 1'b0; enable = 1'b0; srcExt = 1'b0; extClk = 1'b0;
    ovrClear = 1'b0; divisor = '0;
    repeat (5) @(negedge clk);
    chk(convStart == 1'b0, "R1 convStart", convStart, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(convStart == 1'b0 && overrun == 1'b0, "R1 after release", {convStart, overrun}, 0);

    // R2 R3: internal period table
    for (int i = 0; i < NVEC; i++) begin
      enable = 1'b0;
      divisor = VEC_DIV[i];
      repeat (3) @(negedge clk);
      enable = 1'b1;
      waitStrobe(5000, n);
      chk(n == VEC_EXP[i], "R2/R3 first strobe latency", n, VEC_EXP[i]);
      @(negedge clk);
      chk(convStart == 1'b0, "R4 pulse width", convStart, 0);
      waitStrobe(5000, n);
      chk(n + 1 == VEC_EXP[i], "R2/R3 period", n + 1, VEC_EXP[i]);
    end

    // R9: divisor change restarts divider
    divisor = 32'd600;
    waitStrobe(5000, n);
    repeat (100) @(negedge clk);
    divisor = 32'd450;
    waitStrobe(5000, n);
    chk(n == 451, "R9 restart after divisor change", n, 451);

    // R10: extClk ignored in internal mode
    cnt = 0; firstPos = 0;
    for (int j = 1; j <= 450; j++) begin
      @(negedge clk);
      if (convStart) begin
        cnt++;
        if (firstPos == 0) firstPos = j;
      end
      extClk = j[3];
    end
    chk(cnt == 1 && firstPos == 450, "R10 internal ignores extClk", firstPos, 450);
    extClk = 1'b0;

    // R10: no internal strobes in external mode
    srcExt = 1'b1;
    countStrobes(1000, cnt);
    chk(cnt == 0, "R10 no internal strobes in ext mode", cnt, 0);

    // R5: external edge latency
    extClk = 1'b1;
    waitStrobe(10, n);
    chk(n == 3, "R5 external latency", n, 3);
    @(negedge clk);
    chk(convStart == 1'b0, "R4 external pulse width", convStart, 0);
    extClk = 1'b0;

    // R7: edge at 399-cycle spacing is dropped
    repeat (395) @(negedge clk);
    extClk = 1'b1;
    countStrobes(10, cnt);
    chk(cnt == 0, "R7 early edge dropped", cnt, 0);
    chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
    extClk = 1'b0;
    repeat (500) @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

    // R6: edge at exactly 400-cycle spacing accepted
    extClk = 1'b1;
    waitStrobe(10, n);
    chk(n == 3, "R5 accepted after long gap", n, 3);
    @(negedge clk);
    extClk = 1'b0;
    repeat (396) @(negedge clk);
    extClk = 1'b1;
    waitStrobe(10, n);
    chk(n == 3, "R6 edge at 400-cycle spacing accepted", n, 3);
    chk(overrun == 1'b1, "R7 overrun still set", overrun, 1);

    // R8: clear
    @(negedge clk);
    extClk = 1'b0;
    ovrClear = 1'b1;
    @(negedge clk);
    ovrClear = 1'b0;
    chk(overrun == 1'b0, "R8 overrun cleared", overrun, 0);

    // R9: disabled ignores external edges
    enable = 1'b0;
    cnt = 0;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (convStart) cnt++;
      extClk = ((j / 10) % 2) == 1;
    end
    chk(cnt == 0, "R9 no strobes while disabled", cnt, 0);
    chk(overrun == 1'b0, "R9 no overrun while disabled", overrun, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule